// File: doc/BRIEF.md
# Extended Bus Address Register

This block holds the address a CPU presents to a shared system bus. The low sixteen address bits come from the ALU result bus and are captured on one load strobe. Two further high-order address bits (bit 16 and bit 17) sit in separate flip-flops with a strobe of their own. Those flip-flops take their values from the two lowest ALU result bits. The extension bits leave the block in active-low form for the instruction-register logic.

When the CPU holds the bus (the online input is high), the stored sixteen-bit address is driven onto the shared bus address lines in active-low form. Otherwise those lines are released, so another master can place an address there. Whatever address is on the lines is inverted back to true polarity and passed to the address-recognition logic. The stored address is also returned, in true polarity, to the ALU input multiplexer at all times.

A synchronous, active-high reset clears the sixteen-bit register and sets both extension bits.

Top module: `xaddr_reg`

## Requirements
- R1: On a clock edge with `rst` high, `addr_fb` becomes 0 and both extension bits become 1, so `ext_n` reads 2'b00.
- R2: On a clock edge with `ld_addr` high and `rst` low, `addr_fb` takes the value that `alu_res` had at that edge.
- R3: On a clock edge with `ld_addr` low and `rst` low, `addr_fb` keeps its value, whatever `ld_ext` and `alu_res` are doing.
- R4: On a clock edge with `ld_ext` high and `rst` low, address bit 16 takes `alu_res[1]` and address bit 17 takes `alu_res[0]`. They are output as `ext_n[0]` = NOT bit 16 and `ext_n[1]` = NOT bit 17.
- R5: On a clock edge with `ld_ext` low and `rst` low, `ext_n` keeps its value, whatever `ld_addr` and `alu_res` are doing.
- R6: While `online` is high, `bus_addr_n` carries the bitwise inverse of the stored address.
- R7: While `online` is low, the block does not drive `bus_addr_n`, so the lines show exactly the value another driver places on them.
- R8: `addr_fb` always equals the stored address, with `online` high or low.
- R9: `rcv_addr` equals the bitwise inverse of `bus_addr_n` in both modes. While online, this means `rcv_addr` equals the block's own stored address.
- R10: Reset takes priority over both load strobes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| alu_res | input | 16 | ALU result bus, source of the address and of the extension bits |
| ld_addr | input | 1 | Load strobe for the 16-bit address register |
| ld_ext | input | 1 | Load strobe for the two extension bits |
| online | input | 1 | CPU holds the bus; enables the address line drivers |
| bus_addr_n | inout | 16 | Shared bus address lines, active low |
| ext_n | output | 2 | Extension bits, active low: [0] is bit 16, [1] is bit 17 |
| addr_fb | output | 16 | Stored address returned to the ALU input multiplexer |
| rcv_addr | output | 16 | True-polarity address seen on the bus, for address recognition |

## Verification
A wrong bit in the address register appears on `addr_fb` one cycle after the load. It also appears inverted on the bus lines in any cycle the block is online. A swapped or stuck extension bit appears on `ext_n` one cycle after the extension strobe. Drivers that fail to release the lines corrupt the address `rcv_addr` reports for another master in the very cycle the bench drives it. This is why random phases alternate between online and offline with independent bus values.

// File: rtl/xaddr_pkg.sv
package xaddr_pkg;
    localparam int ADDR_W = 16;
    localparam int EXT_W  = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [EXT_W-1:0]  ext_t;

    typedef struct packed {
        ext_t  ext;
        addr_t low;
    } full_addr_t;

    // Extension bit i takes ALU bit (EXT_W-1-i): bit 16 from ALU bit 1, bit 17 from ALU bit 0.
    function automatic ext_t ext_from_alu(input addr_t alu);
        ext_t e;
        for (int i = 0; i < EXT_W; i++) e[i] = alu[EXT_W-1-i];
        return e;
    endfunction
endpackage

// File: rtl/xaddr_low_reg.sv
module xaddr_low_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/xaddr_ext_ff.sv
module xaddr_ext_ff
    import xaddr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  addr_t alu,
    output ext_t  q_n
);
    ext_t q;
    ext_t nxt;

    assign nxt = ext_from_alu(alu);

    for (genvar i = 0; i < EXT_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)       q[i] <= 1'b1;
            else if (load) q[i] <= nxt[i];
        end
        assign q_n[i] = ~q[i];
    end
endmodule

// File: rtl/xaddr_bus_port.sv
module xaddr_bus_port #(
    parameter int W = 16
) (
    input  logic         drive_en,
    input  logic [W-1:0] addr,
    inout  wire  [W-1:0] line_n,
    output logic [W-1:0] seen
);
    assign line_n = drive_en ? ~addr : {W{1'bz}};
    assign seen   = ~line_n;
endmodule

// File: rtl/xaddr_reg.sv
module xaddr_reg
    import xaddr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       alu_res,
    input  logic              ld_addr,
    input  logic              ld_ext,
    input  logic              online,
    inout  wire  [15:0]       bus_addr_n,
    output logic [1:0]        ext_n,
    output logic [15:0]       addr_fb,
    output logic [15:0]       rcv_addr
);
    full_addr_t cur;

    xaddr_low_reg #(.W(ADDR_W)) u_low (
        .clk(clk), .rst(rst), .load(ld_addr), .d(alu_res), .q(cur.low)
    );

    xaddr_ext_ff u_ext (
        .clk(clk), .rst(rst), .load(ld_ext), .alu(alu_res), .q_n(cur.ext)
    );

    xaddr_bus_port #(.W(ADDR_W)) u_port (
        .drive_en(online), .addr(cur.low), .line_n(bus_addr_n), .seen(rcv_addr)
    );

    assign addr_fb = cur.low;
    assign ext_n   = cur.ext;
endmodule

// File: rtl/xaddr_reg_chk.sv
module xaddr_reg_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] alu_res,
    input logic        ld_addr,
    input logic        ld_ext,
    input logic        online,
    input logic [15:0] bus_addr_n,
    input logic [1:0]  ext_n,
    input logic [15:0] addr_fb,
    input logic [15:0] rcv_addr
);
    // R1, R10
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (addr_fb == 16'h0 && ext_n == 2'b00));
    // R2
    a_r2_addr_load: assert property (@(posedge clk) disable iff (rst)
        ld_addr |=> addr_fb == $past(alu_res));
    // R3
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !ld_addr |=> $stable(addr_fb));
    // R4
    a_r4_ext_load: assert property (@(posedge clk) disable iff (rst)
        ld_ext |=> ext_n == ~{$past(alu_res[0]), $past(alu_res[1])});
    // R5
    a_r5_ext_hold: assert property (@(posedge clk) disable iff (rst)
        !ld_ext |=> $stable(ext_n));
    // R6
    a_r6_drive: assert property (@(posedge clk) disable iff (rst)
        online |-> bus_addr_n == ~addr_fb);
    // R9
    a_r9_loopback: assert property (@(posedge clk) disable iff (rst)
        online |-> rcv_addr == addr_fb);
endmodule

bind xaddr_reg xaddr_reg_chk u_chk (
    .clk(clk), .rst(rst), .alu_res(alu_res), .ld_addr(ld_addr), .ld_ext(ld_ext),
    .online(online), .bus_addr_n(bus_addr_n), .ext_n(ext_n), .addr_fb(addr_fb),
    .rcv_addr(rcv_addr)
);

// File: tb/sim_xaddr_reg.sv
`timescale 1ns/1ps
module sim_xaddr_reg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] alu_res = '0;
    logic        ld_addr = 1'b0, ld_ext = 1'b0, online = 1'b0;
    logic        drv_en = 1'b0;
    logic [15:0] drv_val = '0;
    tri   [15:0] bus_addr_n;
    logic [1:0]  ext_n;
    logic [15:0] addr_fb, rcv_addr;

    int checks = 0, failures = 0;
    logic [15:0] exp_addr = '0;
    logic [1:0]  exp_ext = 2'b11;   // true-polarity {bit17, bit16}

    assign bus_addr_n = drv_en ? drv_val : 16'hzzzz;

    always #10 clk = ~clk;

    xaddr_reg u0 (
        .clk(clk), .rst(rst), .alu_res(alu_res), .ld_addr(ld_addr), .ld_ext(ld_ext),
        .online(online), .bus_addr_n(bus_addr_n), .ext_n(ext_n), .addr_fb(addr_fb),
        .rcv_addr(rcv_addr)
    );

    function automatic logic [1:0] ext_pick(input logic [15:0] a);
        return {a[0], a[1]};          // bit17 <- alu[0], bit16 <- alu[1]
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // apply inputs at negedge, advance one edge, update model, check at next negedge
    task automatic step(input logic r, input logic la, input logic le,
                        input logic [15:0] a, input logic on, input logic [15:0] bv);
        rst = r; ld_addr = la; ld_ext = le; alu_res = a; online = on;
        drv_en = ~on; drv_val = bv;
        @(posedge clk);
        if (r) begin exp_addr = '0; exp_ext = 2'b11; end
        else begin
            if (la) exp_addr = a;
            if (le) exp_ext = ext_pick(a);
        end
        @(negedge clk);
        check("R2/R3 addr_fb", addr_fb, exp_addr);
        check("R4/R5 ext_n", {14'h0, ext_n}, {14'h0, ~exp_ext});
        if (on) begin
            check("R6 bus drive", bus_addr_n, ~exp_addr);
            check("R9 loopback", rcv_addr, exp_addr);
            check("R8 feedback online", addr_fb, exp_addr);
        end else begin
            check("R7 released", bus_addr_n, bv);
            check("R9 receive", rcv_addr, ~bv);
            check("R8 feedback offline", addr_fb, exp_addr);
        end
    endtask

    initial begin : watchdog
        #3_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        step(1'b1, 1'b0, 1'b0, 16'h0, 1'b0, 16'h5A5A);
        check("R1 reset addr", addr_fb, 16'h0);
        check("R1 reset ext_n", {14'h0, ext_n}, 16'h0);
        step(1'b0, 1'b1, 1'b1, 16'hFFFE, 1'b1, 16'h0);   // ext <- {0,1}
        step(1'b0, 1'b0, 1'b1, 16'h0001, 1'b1, 16'h0);   // R3: ext only
        step(1'b0, 1'b1, 1'b0, 16'h8001, 1'b0, 16'h1234); // R5: addr only
        step(1'b1, 1'b1, 1'b1, 16'h0000, 1'b1, 16'h0);   // R10: reset wins
        check("R10 reset over strobes", addr_fb, 16'h0);
        step(1'b0, 1'b1, 1'b1, 16'hFFFF, 1'b1, 16'h0);
        step(1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'hFFFF);
        step(1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step((r[7:0] == 8'd0), r[8], r[9], 16'($urandom), r[10], 16'($urandom));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule